// File: doc/BRIEF.md
# Comparator Channel Control and Interrupt Unit

This unit is the digital side of three identical analog comparator channels. Software programs each channel through a small register file. It turns each channel on or off, picks the threshold code for the resistor ladder, sets the output polarity and enables the interrupt. The unit sends the threshold code and the enable to the analog macro, and it receives back one raw comparator output per channel.

Inside the unit, each raw output goes through a two-stage synchronizer. The unit then inverts the signal if the channel's polarity bit asks for it and watches it for the edge type picked in a shared edge-select register. A detected edge sets a sticky pending flag, and only a software write of 0 clears that flag. An interrupt request line per channel is high while that channel's pending flag and its interrupt enable are both set.

The live status bit lets software read the synchronized comparator level directly. The threshold codes run from 0.45 to 0.80 of the supply, in steps of 0.05.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, and `irq`, `ref_code` and `cmp_en` are all 0.
- R2: Channel k is at address k (0 to 2) and the edge-select register is at address 3. A channel register holds these fields: bits 7:5 threshold code, bit 4 enable, bit 3 interrupt enable, bit 2 polarity, bit 1 live status, bit 0 pending.
- R3: `ref_code[3k+2:3k]` equals channel k's threshold field and `cmp_en[k]` equals its enable bit. Neither output changes unless that channel's register is written.
- R4: The status bit reads the raw comparator level (1 means the negative input is below the threshold) two clock edges after that level is sampled. It reads 0 while the channel is disabled, and writes to it are ignored.
- R5: With polarity 0, edges are detected on the raw level. With polarity 1, they are detected on the inverted level.
- R6: Edge-select bits [2k+1:2k] choose the edge for channel k: 00 falling, 01 rising, 10 or 11 both.
- R7: An enabled channel sets its pending bit one clock after a selected edge appears on its synchronized, polarity-adjusted level. A disabled channel never sets it.
- R8: Writing 0 to a pending bit clears it. Writing 1 leaves it unchanged, and the hardware never clears it.
- R9: If a selected edge occurs in the same cycle as a software clear, the pending bit stays set.
- R10: `irq[k]` is high exactly while channel k's pending bit and interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cmp_raw | input | 3 | Raw comparator outputs, asynchronous |
| ref_code | output | 9 | Threshold code, 3 bits per channel |
| cmp_en | output | 3 | Analog enable per channel |
| irq | output | 3 | Interrupt request per channel |

## Verification
The assertions assume that writes come only through `bus_we` with a stable address and data around the clock edge. They also assume that `cmp_raw` holds each level for at least two clocks, so the synchronizer never misses a level. The stimulus holds every raw level for four clocks before sampling, and it changes polarity only while a channel is disabled, so no polarity-induced edges appear. The same-cycle clear case is timed so that the clear write lands on the clock edge where the pending bit would be set.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  typedef enum logic [1:0] {
    EDGE_FALL  = 2'b00,
    EDGE_RISE  = 2'b01,
    EDGE_BOTH  = 2'b10,
    EDGE_BOTHX = 2'b11
  } edge_sel_e;

  localparam int unsigned CH_CTRL_BITS = 5;

  function automatic logic edge_match(input logic [1:0] sel, input logic prev, input logic cur);
    logic rise;
    logic fall;
    rise = ~prev & cur;
    fall = prev & ~cur;
    case (edge_sel_e'(sel))
      EDGE_FALL: edge_match = fall;
      EDGE_RISE: edge_match = rise;
      default:   edge_match = rise | fall;
    endcase
  endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
  import cmp_pkg::*;
#(
  parameter int unsigned REF_W  = 3,
  localparam int unsigned DATA_W = REF_W + CH_CTRL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        edge_sel,
  input  logic              cmp_s,
  output logic [DATA_W-1:0] rdata,
  output logic [REF_W-1:0]  ref_o,
  output logic              en_o,
  output logic              pend_o,
  output logic              hit_o,
  output logic              irq_o
);

  logic [REF_W-1:0] ref_q, ref_d;
  logic             en_q, en_d;
  logic             ie_q, ie_d;
  logic             pol_q, pol_d;
  logic             pend_q, pend_d;
  logic             prev_q, prev_d;
  logic             adj;
  logic             hit;
  logic             sw_clr;

  always_comb begin
    adj    = cmp_s ^ pol_q;
    hit    = en_q & edge_match(edge_sel, prev_q, adj);
    sw_clr = wr_en & ~wdata[0];
    ref_d  = ref_q;
    en_d   = en_q;
    ie_d   = ie_q;
    pol_d  = pol_q;
    if (wr_en) begin
      ref_d = wdata[DATA_W-1:CH_CTRL_BITS];
      en_d  = wdata[4];
      ie_d  = wdata[3];
      pol_d = wdata[2];
    end
    pend_d = hit | (pend_q & ~sw_clr);
    prev_d = adj;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      pol_q  <= 1'b0;
      pend_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      en_q   <= en_d;
      ie_q   <= ie_d;
      pol_q  <= pol_d;
      pend_q <= pend_d;
      prev_q <= prev_d;
    end
  end

  assign rdata  = {ref_q, en_q, ie_q, pol_q, cmp_s & en_q, pend_q};
  assign ref_o  = ref_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign hit_o  = hit;
  assign irq_o  = pend_q & ie_q;

endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
  import cmp_pkg::*;
#(
  parameter int unsigned NCH         = 3,
  parameter int unsigned REF_W       = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = $clog2(NCH + 1),
  localparam int unsigned DATA_W     = REF_W + CH_CTRL_BITS,
  localparam int unsigned ESEL_W     = 2 * NCH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [NCH-1:0]         cmp_raw,
  output logic [NCH*REF_W-1:0]   ref_code,
  output logic [NCH-1:0]         cmp_en,
  output logic [NCH-1:0]         irq
);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [NCH-1:0]    cmp_s;
  logic [ESEL_W-1:0] esel_q, esel_d;
  logic              esel_wr;
  logic [DATA_W-1:0] ch_rdata [NCH];
  logic [NCH-1:0]    pend_vec;
  logic [NCH-1:0]    hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  cmp_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (cmp_raw),
    .q     (cmp_s)
  );

  always_comb begin
    esel_wr = bus_we && (bus_addr == ADDR_W'(NCH));
    esel_d  = esel_wr ? bus_wdata[ESEL_W-1:0] : esel_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) esel_q <= '0;
    else             esel_q <= esel_d;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    cmp_channel #(.REF_W(REF_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_en    (bus_we && (bus_addr == ADDR_W'(k))),
      .wdata    (bus_wdata),
      .edge_sel (esel_q[2*k +: 2]),
      .cmp_s    (cmp_s[k]),
      .rdata    (ch_rdata[k]),
      .ref_o    (ref_code[k*REF_W +: REF_W]),
      .en_o     (cmp_en[k]),
      .pend_o   (pend_vec[k]),
      .hit_o    (hit_vec[k]),
      .irq_o    (irq[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(NCH)) begin
      bus_rdata[ESEL_W-1:0] = esel_q;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (bus_addr == ADDR_W'(i)) bus_rdata = ch_rdata[i];
      end
    end
  end

endmodule

module cmp_irq_ctrl_chk #(
  parameter int unsigned NCH    = 3,
  parameter int unsigned REF_W  = 3,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [NCH-1:0]       pend,
  input logic [NCH-1:0]       hit,
  input logic [NCH-1:0]       en,
  input logic [NCH*REF_W-1:0] ref_code
);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_pend_sw_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend[g]) |-> $past(bus_we && bus_addr == ADDR_W'(g) && !bus_wdata[0]));

    assert_no_set_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[g]) |-> $past(en[g]));

    assert_edge_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_we && bus_addr == ADDR_W'(g) && !bus_wdata[0] && hit[g]) |-> pend[g]);

    assert_ref_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_we && bus_addr == ADDR_W'(g)) |-> $stable(ref_code[g*REF_W +: REF_W]));

    assert_en_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_we && bus_addr == ADDR_W'(g)) |-> $stable(en[g]));
  end

endmodule

bind cmp_irq_ctrl cmp_irq_ctrl_chk #(
  .NCH(NCH), .REF_W(REF_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pend      (pend_vec),
  .hit       (hit_vec),
  .en        (cmp_en),
  .ref_code  (ref_code)
);

// File: tb/cmp_irq_ctrl_tb.sv
module cmp_irq_ctrl_tb;

  logic       clk;
  logic       rst_n;
  logic       bus_we;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [2:0] cmp_raw;
  logic [8:0] ref_code;
  logic [2:0] cmp_en;
  logic [2:0] irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  cmp_irq_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cmp_raw   (cmp_raw),
    .ref_code  (ref_code),
    .cmp_en    (cmp_en),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] chv(input logic [2:0] r, input logic en, input logic ie,
                                     input logic pol, input logic st, input logic pd);
    return {r, en, ie, pol, st, pd};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_raw(input int ch, input logic v);
    @(negedge clk);
    cmp_raw[ch] = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic cfg(input logic [1:0] ch, input logic [2:0] r, input logic ie, input logic pol);
    wr(ch, chv(r, 1'b0, ie, pol, 1'b0, 1'b1));
    wr(ch, chv(r, 1'b1, ie, pol, 1'b0, 1'b0));
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reg", {24'd0, d}, 32'd0);
    end
    chk("R1 irq", {29'd0, irq}, 0);
    chk("R1 ref_code", {23'd0, ref_code}, 0);
    chk("R1 cmp_en", {29'd0, cmp_en}, 0);
  endtask

  task automatic t_config;
    logic [7:0] d;
    wr(2'd1, chv(3'd5, 1, 1, 0, 1, 1));
    rd(2'd1, d);
    chk("R2/R4/R8 ch1 readback", {24'd0, d}, {24'd0, chv(3'd5, 1, 1, 0, 0, 0)});
    chk("R3 ref_code ch1", {29'd0, ref_code[5:3]}, 5);
    chk("R3 cmp_en", {29'd0, cmp_en}, 3'b010);
    rd(2'd0, d);
    chk("R2 ch0 untouched", {24'd0, d}, 0);
    rd(2'd2, d);
    chk("R2 ch2 untouched", {24'd0, d}, 0);
    wr(2'd3, 8'h24);
    rd(2'd3, d);
    chk("R2/R6 edge select", {24'd0, d}, 32'h24);
  endtask

  task automatic t_fall;
    logic [7:0] d;
    cfg(2'd0, 3'd2, 1'b1, 1'b0);
    set_raw(0, 1'b1);
    rd(2'd0, d);
    chk("R6/R4 rise ignored on falling select", {24'd0, d}, {24'd0, chv(3'd2, 1, 1, 0, 1, 0)});
    chk("R10 irq low", {31'd0, irq[0]}, 0);
    set_raw(0, 1'b0);
    rd(2'd0, d);
    chk("R7 falling sets pending", {24'd0, d}, {24'd0, chv(3'd2, 1, 1, 0, 0, 1)});
    chk("R10 irq high", {31'd0, irq[0]}, 1);
  endtask

  task automatic t_clear;
    logic [7:0] d;
    set_raw(0, 1'b1);
    rd(2'd0, d);
    chk("R8 hardware keeps pending", {31'd0, d[0]}, 1);
    wr(2'd0, chv(3'd2, 1, 1, 0, 0, 1));
    rd(2'd0, d);
    chk("R8 write 1 keeps pending", {31'd0, d[0]}, 1);
    wr(2'd0, chv(3'd2, 1, 1, 0, 0, 0));
    rd(2'd0, d);
    chk("R8 write 0 clears", {24'd0, d}, {24'd0, chv(3'd2, 1, 1, 0, 1, 0)});
    chk("R10 irq drops", {31'd0, irq[0]}, 0);
  endtask

  task automatic t_rise;
    logic [7:0] d;
    cfg(2'd1, 3'd4, 1'b1, 1'b0);
    set_raw(1, 1'b1);
    rd(2'd1, d);
    chk("R6 rising sets ch1", {31'd0, d[0]}, 1);
    chk("R10 irq ch1", {31'd0, irq[1]}, 1);
    wr(2'd1, chv(3'd4, 1, 1, 0, 0, 0));
    set_raw(1, 1'b0);
    rd(2'd1, d);
    chk("R6 falling ignored ch1", {31'd0, d[0]}, 0);
  endtask

  task automatic t_both;
    logic [7:0] d;
    cfg(2'd2, 3'd7, 1'b1, 1'b0);
    set_raw(2, 1'b1);
    rd(2'd2, d);
    chk("R6 both: rise", {31'd0, d[0]}, 1);
    wr(2'd2, chv(3'd7, 1, 1, 0, 0, 0));
    set_raw(2, 1'b0);
    rd(2'd2, d);
    chk("R6 both: fall", {31'd0, d[0]}, 1);
    chk("R3 ref_code ch2", {29'd0, ref_code[8:6]}, 7);
  endtask

  task automatic t_pol;
    logic [7:0] d;
    cfg(2'd0, 3'd2, 1'b1, 1'b1);
    set_raw(0, 1'b0);
    rd(2'd0, d);
    chk("R5 inverted rise ignored", {31'd0, d[0]}, 0);
    set_raw(0, 1'b1);
    rd(2'd0, d);
    chk("R5 inverted fall sets", {24'd0, d}, {24'd0, chv(3'd2, 1, 1, 1, 1, 1)});
    wr(2'd0, chv(3'd2, 1, 1, 1, 0, 0));
  endtask

  task automatic t_disabled;
    logic [7:0] d;
    wr(2'd2, chv(3'd7, 0, 1, 0, 0, 0));
    set_raw(2, 1'b1);
    rd(2'd2, d);
    chk("R4/R7 disabled: no status, no pending", {24'd0, d}, {24'd0, chv(3'd7, 0, 1, 0, 0, 0)});
    set_raw(2, 1'b0);
    rd(2'd2, d);
    chk("R7 disabled fall ignored", {31'd0, d[0]}, 0);
    chk("R10 irq ch2 low", {31'd0, irq[2]}, 0);
  endtask

  task automatic t_ie;
    logic [7:0] d;
    cfg(2'd1, 3'd4, 1'b0, 1'b0);
    set_raw(1, 1'b1);
    rd(2'd1, d);
    chk("R7 pending with ie=0", {31'd0, d[0]}, 1);
    chk("R10 irq masked", {31'd0, irq[1]}, 0);
    wr(2'd1, chv(3'd4, 1, 1, 0, 0, 1));
    rd(2'd1, d);
    chk("R10 irq after ie set", {31'd0, irq[1]}, 1);
    wr(2'd1, chv(3'd4, 1, 1, 0, 0, 0));
  endtask

  task automatic t_win;
    logic [7:0] d;
    set_raw(1, 1'b0);
    set_raw(1, 1'b1);
    rd(2'd1, d);
    chk("R7 pending before race", {31'd0, d[0]}, 1);
    set_raw(1, 1'b0);
    @(negedge clk);
    cmp_raw[1] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = chv(3'd4, 1, 1, 0, 0, 0);
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    rd(2'd1, d);
    chk("R9 edge beats clear", {24'd0, d}, {24'd0, chv(3'd4, 1, 1, 0, 1, 1)});
    wr(2'd1, chv(3'd4, 1, 1, 0, 0, 0));
    rd(2'd1, d);
    chk("R8 plain clear after race", {31'd0, d[0]}, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; cmp_raw = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_config();
    t_fall();
    t_clear();
    t_rise();
    t_both();
    t_pol();
    t_disabled();
    t_ie();
    t_win();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule